// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a 24-bit down-counter that produces a regular time base for an operating system or scheduler. Software programs a reload value, chooses whether the counter advances on every core clock cycle or only on cycles where an external reference tick strobe is high, and then enables it. The counter loads the reload value and counts down one step per selected tick. When it passes from 1 to 0 it raises a sticky count flag and, if the interrupt enable is set, a single-cycle exception request. On the next tick it reloads and runs on, so one period spans reload+1 ticks.

Access goes through a simple single-cycle register port: valid, write, a byte address and 32-bit data. Read data is combinational in the cycle of the read. Reads and writes carry side effects: reading the control register clears the count flag, and any write to the current-value register restarts the period. A reload value of zero makes the counter stop itself once it has expired.

Top module: `periodic_tick_timer`

## Requirements
- R1: A synchronous active-low reset clears the control bits, the count flag, the reload value and the current value, and holds the exception request low.
- R2: The control register at offset 0x10 has enable at bit 0, interrupt enable at bit 1 and clock source at bit 2 (1 = every core clock, 0 = only on reference tick cycles); only these three bits are writable, the count flag reads at bit 16, and all other bits read 0.
- R3: A read of the control register returns the flag as it stands and clears it at the end of that cycle; if the counter sets the flag in the same cycle, the flag stays set.
- R4: When the counter steps from 1 to 0 the count flag is set; if interrupt enable is 1, the exception request output is high for exactly that one cycle in which the current value first reads 0, and it stays low when interrupt enable is 0.
- R5: A control write that changes enable from 0 to 1 loads the reload value into the counter; each following selected tick decrements it, and the tick after it reads 0 loads the reload value again, giving a period of reload+1 ticks.
- R6: Any write to the current-value register at offset 0x18, whatever the data, loads the reload value into the counter and clears the count flag.
- R7: The current-value register reads 0 while enable is 0.
- R8: The reload register at offset 0x14 holds 24 bits; bits 31 to 24 are ignored on write and read 0.
- R9: The calibration register at offset 0x1C reads the constant 10000 and ignores writes; reads of any unmapped offset return 0.
- R10: With clock source 0 the counter changes only on cycles where the reference tick input is high.
- R11: When the counter is already 0 and a tick arrives while the reload value is 0, enable is cleared instead of reloading, so the timer stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | External reference tick strobe, one cycle per tick |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read, 0 otherwise |
| exc_req | output | 1 | One-cycle exception request on expiry |

## Verification
The hardest situations to reach are the self-stop with a zero reload and the reference-tick mode, because both need the counter parked at a known small value before the decisive tick. The bench disables the core-clock source, loads a small reload, and then hands out reference ticks one at a time, lowering the reload to zero while the counter sits at 1 so that the expiry and the stop fall on two chosen cycles. Expiry cycles themselves are caught by reading the current value every cycle while polling for the exception pulse, so the pulse and the zero reading are compared in the same cycle.

// File: rtl/tmr_pkg.sv
// Package: shared constants and types of the periodic tick timer.
// Assumes a 32-bit register port and byte offsets decoded in full.
package tmr_pkg;

    localparam int DATA_W    = 32;
    localparam int CNT_W     = 24;
    localparam int ADDR_W    = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_CUR    = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_CALIB  = 12'h01C;

    localparam int BIT_EN   = 0;
    localparam int BIT_IE   = 1;
    localparam int BIT_SRC  = 2;
    localparam int BIT_FLAG = 16;

    localparam logic [DATA_W-1:0] CALIB_DEFAULT = 32'd10000;

    // Writable control bits, packed so that {src, ie, en} matches data [2:0]
    typedef struct packed {
        logic src;
        logic ie;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/tmr_ctrl.sv
// Module: control bits, sticky count flag and exception request.
// Assumes the strobes from the decoder are single-cycle and mutually
// exclusive per register; stop_i and wrap_i come from the counter.
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_ctrl_i,
    input  logic   rd_ctrl_i,
    input  logic   wr_cur_i,
    input  logic   [2:0] wdata_lo_i,
    input  logic   stop_i,
    input  logic   wrap_i,
    output ctrl_t  ctrl_o,
    output logic   flag_o,
    output logic   exc_req_o
);

    ctrl_t ctrl_q;
    logic  flag_q;
    logic  exc_q;

    // Control bits: bus write has priority over the counter's self-stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl_i) begin
            ctrl_q <= ctrl_t'(wdata_lo_i);
        end else if (stop_i) begin
            ctrl_q.en <= 1'b0;
        end
    end

    // Count flag: restart clears, expiry sets, control read clears last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (wr_cur_i) begin
            flag_q <= 1'b0;
        end else if (wrap_i) begin
            flag_q <= 1'b1;
        end else if (rd_ctrl_i) begin
            flag_q <= 1'b0;
        end
    end

    // Exception request: one cycle, aligned with the counter reaching zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_q <= 1'b0;
        end else begin
            exc_q <= wrap_i & ctrl_q.ie;
        end
    end

    assign ctrl_o    = ctrl_q;
    assign flag_o    = flag_q;
    assign exc_req_o = exc_q;

    // R4
    exc_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_q |-> flag_q);

    // R4
    exc_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_q |=> !exc_q);

    // R6
    restart_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cur_i |=> !flag_q);

    // R11
    self_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !wr_ctrl_i) |=> !ctrl_q.en);

endmodule

// File: rtl/tmr_count.sv
// Module: reload register and the down-counter with tick selection.
// Assumes load_i already merges the enable rising edge and restart writes.
module tmr_count #(
    parameter int CNT_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              src_core_i,
    input  logic              ref_tick_i,
    input  logic              wr_reload_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  reload_o,
    output logic [CNT_W-1:0]  cur_o,
    output logic              wrap_o,
    output logic              stop_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cur_q;
    logic             tick;
    logic             run;
    logic             at_zero;
    logic             at_one;

    // Tick selection and step qualification
    always_comb begin
        tick    = src_core_i | ref_tick_i;
        run     = en_i & tick & ~load_i;
        at_zero = (cur_q == '0);
        at_one  = (cur_q == ONE);
    end

    // Reload register: upper data bits are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_reload_i) begin
            reload_q <= wdata_i[CNT_W-1:0];
        end
    end

    // Current value: forced load, wrap-around reload or decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (load_i) begin
            cur_q <= reload_q;
        end else if (run) begin
            if (at_zero) begin
                cur_q <= reload_q;
            end else begin
                cur_q <= cur_q - ONE;
            end
        end
    end

    assign wrap_o   = run & at_one;
    assign stop_o   = run & at_zero & (reload_q == '0);
    assign reload_o = reload_q;
    assign cur_o    = cur_q;

    // R4
    wrap_reaches_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cur_q == '0));

    // R10
    no_tick_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_i) |=> $stable(cur_q));

endmodule

// File: rtl/tmr_rdmux.sv
// Module: read data selection for the timer registers.
// Assumes rd_en_i is already qualified with valid and not write.
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter logic [DATA_W-1:0] CALIB_VAL = CALIB_DEFAULT
) (
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  ctrl_t             ctrl_i,
    input  logic              flag_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [CNT_W-1:0]  cur_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int PAD_W = DATA_W - CNT_W;

    logic [DATA_W-1:0] ctrl_word;

    // Control/status word assembly
    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_EN]   = ctrl_i.en;
        ctrl_word[BIT_IE]   = ctrl_i.ie;
        ctrl_word[BIT_SRC]  = ctrl_i.src;
        ctrl_word[BIT_FLAG] = flag_i;
    end

    // Register select; zero when idle or unmapped
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (addr_i)
                OFS_CTRL:   rdata_o = ctrl_word;
                OFS_RELOAD: rdata_o = {{PAD_W{1'b0}}, reload_i};
                OFS_CUR:    rdata_o = ctrl_i.en ? {{PAD_W{1'b0}}, cur_i} : '0;
                OFS_CALIB:  rdata_o = CALIB_VAL;
                default:    rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/periodic_tick_timer.sv
// Module: top of the periodic tick timer; decodes the register port and
// ties control, counter and read mux together.
// Assumes one access per cycle and full-offset decoding.
module periodic_tick_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter logic [31:0] CALIB_VAL = 32'd10000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        exc_req
);

    logic             wr_ctrl, rd_ctrl, wr_reload, wr_cur, rd_any;
    logic             load;
    logic             wrap, stop, flag;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_v, cur_v;

    // Access decode into per-register strobes
    always_comb begin
        rd_any    = bus_valid & ~bus_write;
        wr_ctrl   = bus_valid &  bus_write & (bus_addr == OFS_CTRL);
        rd_ctrl   = rd_any & (bus_addr == OFS_CTRL);
        wr_reload = bus_valid &  bus_write & (bus_addr == OFS_RELOAD);
        wr_cur    = bus_valid &  bus_write & (bus_addr == OFS_CUR);
        load      = (wr_ctrl & bus_wdata[BIT_EN] & ~ctrl.en) | wr_cur;
    end

    tmr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl_i  (wr_ctrl),
        .rd_ctrl_i  (rd_ctrl),
        .wr_cur_i   (wr_cur),
        .wdata_lo_i (bus_wdata[2:0]),
        .stop_i     (stop),
        .wrap_i     (wrap),
        .ctrl_o     (ctrl),
        .flag_o     (flag),
        .exc_req_o  (exc_req)
    );

    tmr_count #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (ctrl.en),
        .src_core_i  (ctrl.src),
        .ref_tick_i  (ref_tick),
        .wr_reload_i (wr_reload),
        .load_i      (load),
        .wdata_i     (bus_wdata),
        .reload_o    (reload_v),
        .cur_o       (cur_v),
        .wrap_o      (wrap),
        .stop_o      (stop)
    );

    tmr_rdmux #(.CNT_W(CNT_W), .CALIB_VAL(CALIB_VAL)) u_rdmux (
        .rd_en_i  (rd_any),
        .addr_i   (bus_addr),
        .ctrl_i   (ctrl),
        .flag_i   (flag),
        .reload_i (reload_v),
        .cur_i    (cur_v),
        .rdata_o  (bus_rdata)
    );

    // R7
    idle_cur_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_addr == OFS_CUR && !ctrl.en) |-> (bus_rdata == '0));

    // R9
    calib_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && bus_addr == OFS_CALIB) |-> (bus_rdata == CALIB_VAL));

    // R3
    read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !wrap) |=> !flag);

    // R5
    enable_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[BIT_EN] && !ctrl.en) |=> (cur_v == $past(reload_v)));

endmodule

// File: tb/periodic_tick_timer_tb.sv
module periodic_tick_timer_tb;

    localparam logic [11:0] A_CTRL = 12'h010;
    localparam logic [11:0] A_RLD  = 12'h014;
    localparam logic [11:0] A_CUR  = 12'h018;
    localparam logic [11:0] A_CAL  = 12'h01C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        exc_req;

    int n_cmp = 0;
    int n_bad = 0;
    int n_exc = 0;
    bit started = 0;
    bit done = 0;

    // Reference model state
    bit     m_en, m_ie, m_src, m_flag, m_exc;
    longint m_reload, m_cur;

    always #10 clk = ~clk;

    periodic_tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .exc_req(exc_req)
    );

    function automatic string req_of(input logic [11:0] a);
        case (a)
            A_CTRL:  return "R2/R3";
            A_RLD:   return "R8";
            A_CUR:   return "R5/R7";
            A_CAL:   return "R9";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    // Reference model: one step per clock edge
    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_exc = 0;
            m_reload = 0; m_cur = 0;
        end else begin
            bit wc, wr, wcur, rc, ld, tk, run, wrap, stop;
            bit n_en, n_flag;
            longint n_cur;
            wc   = bus_valid && bus_write && bus_addr == A_CTRL;
            wr   = bus_valid && bus_write && bus_addr == A_RLD;
            wcur = bus_valid && bus_write && bus_addr == A_CUR;
            rc   = bus_valid && !bus_write && bus_addr == A_CTRL;
            tk   = m_src || ref_tick;
            ld   = (wc && bus_wdata[0] && !m_en) || wcur;
            run  = m_en && tk && !ld;
            wrap = run && m_cur == 1;
            stop = run && m_cur == 0 && m_reload == 0;
            n_flag = wcur ? 0 : wrap ? 1 : rc ? 0 : m_flag;
            if (ld) n_cur = m_reload;
            else if (run) n_cur = (m_cur == 0) ? m_reload : m_cur - 1;
            else n_cur = m_cur;
            n_en = m_en;
            m_exc = wrap && m_ie;
            if (wc) begin
                n_en = bus_wdata[0]; m_ie = bus_wdata[1]; m_src = bus_wdata[2];
            end else if (stop) begin
                n_en = 0;
            end
            if (wr) m_reload = bus_wdata & 32'h00FF_FFFF;
            m_en = n_en; m_flag = n_flag; m_cur = n_cur;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started) begin
            longint exp_rd;
            exp_rd = 0;
            if (bus_valid && !bus_write) begin
                case (bus_addr)
                    A_CTRL: exp_rd = (longint'(m_flag) << 16) | (m_src << 2) | (m_ie << 1) | m_en;
                    A_RLD:  exp_rd = m_reload;
                    A_CUR:  exp_rd = m_en ? m_cur : 0;
                    A_CAL:  exp_rd = 10000;
                    default: exp_rd = 0;
                endcase
            end
            check(req_of(bus_addr), bus_rdata, exp_rd);
            check("R4", exc_req, m_exc);
            if (exc_req) n_exc++;
        end
    end

    task automatic step();
        @(posedge clk); #1;
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk); d = bus_rdata;
        step();
    endtask

    task automatic idle(input int n);
        bus_valid = 0;
        repeat (n) step();
    endtask

    // Read current value every cycle until the exception pulse appears
    task automatic wait_expiry(input string req);
        bit seen;
        seen = 0;
        for (int i = 0; i < 64 && !seen; i++) begin
            bus_valid = 1; bus_write = 0; bus_addr = A_CUR;
            @(negedge clk);
            if (exc_req) begin
                seen = 1;
                check(req, bus_rdata, 0);
            end
            step();
        end
        check(req, seen, 1);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();

        // R1: reset state
        rd(A_CTRL, d); check("R1", d, 0);
        rd(A_RLD, d);  check("R1", d, 0);
        rd(A_CUR, d);  check("R1", d, 0);

        // R2: only low three bits writable
        wr(A_CTRL, 32'hFFFF_FFFA);
        rd(A_CTRL, d); check("R2", d, 32'h2);
        wr(A_CTRL, 32'h0);

        // R8: reload width
        wr(A_RLD, 32'hAB00_0005);
        rd(A_RLD, d); check("R8", d, 32'h5);

        // R9: calibration constant, unmapped and ignored write
        rd(A_CAL, d); check("R9", d, 10000);
        rd(12'h020, d); check("R9", d, 0);
        wr(A_CAL, 32'h0);
        rd(A_CAL, d); check("R9", d, 10000);

        // R5: enable loads reload
        wr(A_CTRL, 32'h7);
        rd(A_CUR, d); check("R5", d, 5);

        // R4: pulse aligned with zero
        wait_expiry("R4");

        // R3: flag read then cleared
        rd(A_CTRL, d); check("R3", d, 32'h1_0007);
        rd(A_CTRL, d); check("R3", d, 32'h7);

        // R6: restart write reloads and clears flag
        wait_expiry("R4");
        wr(A_CUR, 32'hDEAD_BEEF);
        rd(A_CUR, d);  check("R6", d, 5);
        rd(A_CTRL, d); check("R6", d, 32'h7);

        // R7: disabled reads zero
        wr(A_CTRL, 32'h6);
        rd(A_CUR, d);  check("R7", d, 0);
        rd(A_CTRL, d); check("R7", d, 32'h6);

        // R10: reference tick source
        wr(A_RLD, 32'h3);
        wr(A_CTRL, 32'h3);
        idle(5);
        rd(A_CUR, d); check("R10", d, 3);
        ref_tick = 1; idle(2); ref_tick = 0;
        rd(A_CUR, d); check("R10", d, 1);

        // R11: zero reload stops after expiry
        wr(A_RLD, 32'h0);
        ref_tick = 1; idle(2); ref_tick = 0;
        rd(A_CTRL, d); check("R11", d, 32'h1_0002);
        rd(A_CUR, d);  check("R11", d, 0);

        // R4: no pulse with interrupt enable clear, flag still set
        wr(A_RLD, 32'h2);
        wr(A_CTRL, 32'h5);
        n_exc = 0;
        idle(10);
        check("R4", n_exc, 0);
        rd(A_CTRL, d); check("R4", d, 32'h1_0005);

        // R1: reset while running
        rst_n = 0; idle(2); rst_n = 1; step();
        rd(A_CTRL, d); check("R1", d, 0);
        rd(A_RLD, d);  check("R1", d, 0);
        rd(A_CUR, d);  check("R1", d, 0);
        check("R1", exc_req, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1-watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule